// File: doc/BRIEF.md
# Multi-Mode Timer Counter with Prescaler

This block is the timebase of a general-purpose timer. A 16-bit count advances on divided ticks of one of four clock-enable sources. A 2-bit mode field selects how it counts: it can be halted, count up to a period value and restart at zero, run freely across the whole range, or count up to the period and back down to zero. The divider can be set to 1, 2, 4 or 8.

A one-cycle clear command restarts the count, the divider and the up/down direction together. A sticky overflow flag marks the end of each cycle of the counter. The flag drives an interrupt request, which is gated by an enable input. The block also drives the current count and a period-match strobe, which compare and capture channels outside the block use. All clock sources are enable pulses in the same clock domain as `clk_i`.

Top module: `mm_timer`

## Requirements
- R1: With mode_i = 00 (stop) the count does not change whatever the source pulses are, and no overflow is flagged.
- R2: With mode_i = 01 (up) the count rises by one per divided tick. When a tick arrives with the count equal to period_i, the count goes to 0 and ovf_flag_o is set one cycle later.
- R3: With mode_i = 10 (continuous) the count rises to 0xFFFF, then wraps to 0 and sets ovf_flag_o.
- R4: With mode_i = 11 (up/down) the count rises to period_i and then falls by one per tick. When it reaches 0 on the way down, ovf_flag_o is set and the count rises again.
- R5: div_sel_i values 00, 01, 10 and 11 give one divided tick per 1, 2, 4 and 8 pulses of the selected source.
- R6: src_sel_i (0 to 3) picks src_tick_i[src_sel_i]. Pulses on the other sources have no effect.
- R7: A clr_i pulse sets the count to 0, restarts the divider and sets the direction to up, all in the next cycle. It wins over a tick in the same cycle.
- R8: irq_o equals ovf_flag_o AND irq_en_i. The flag stays set until flag_clr_i is pulsed. A new overflow in the same cycle as flag_clr_i leaves the flag set.
- R9: equ0_o is high while the count equals period_i and the mode is not stop.
- R10: In up mode, if the count is already above period_i, counting continues to 0xFFFF and wraps to 0 without setting the flag. Normal periods follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Clock-enable pulse per source |
| src_sel_i | input | 2 | Source select |
| div_sel_i | input | 2 | Divider select (1/2/4/8) |
| mode_i | input | 2 | Count mode: 00 stop, 01 up, 10 continuous, 11 up/down |
| period_i | input | 16 | Period value |
| clr_i | input | 1 | Clear pulse for count, divider and direction |
| flag_clr_i | input | 1 | Clears the overflow flag |
| irq_en_i | input | 1 | Overflow interrupt enable |
| count_o | output | 16 | Current count |
| equ0_o | output | 1 | Count equals period |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
A wrong direction bit in up/down mode shows on count_o at the next divided tick, because the count moves the wrong way. It also shows later as a missing overflow flag at the bottom. A divider phase that survives a clear shows as a count that rises one or more source pulses too early. The bench catches this by counting ticks across a clear. A wrong count in up mode shows as a flag set too early or too late relative to the period. Long runs through 0xFFFF check the wrap in both continuous mode and up mode, and confirm that the flag does or does not follow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_UPDN = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int NUM_SRC   = 4,
  parameter int DIV_SEL_W = 2,
  localparam int SRC_SEL_W = $clog2(NUM_SRC),
  localparam int DIV_CNT_W = (2 ** DIV_SEL_W) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   src_tick_i,
  input  logic [SRC_SEL_W-1:0] src_sel_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 run_i,
  input  logic                 clr_i,
  output logic                 tick_o
);
  logic                 src_tick;
  logic [DIV_CNT_W-1:0] div_q, lim;

  assign src_tick = src_tick_i[src_sel_i];
  assign lim      = DIV_CNT_W'((32'd1 << div_sel_i) - 32'd1);
  assign tick_o   = run_i && src_tick && (div_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (clr_i)             div_q <= '0;
    else if (run_i && src_tick) div_q <= (div_q >= lim) ? '0 : div_q + 1'b1;
  end

  AST_DIV_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (div_q == '0)); // R7
  AST_DIV_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(run_i && src_tick)) |=> $stable(div_q)); // R6
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             tick_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dn_q, dn_d, ovf;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    ovf   = 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          if (cnt_q == period_i) begin
            cnt_d = '0;
            ovf   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;  // wraps past all-ones when above period
          end
        end
        MODE_CONT: begin
          cnt_d = cnt_q + 1'b1;
          ovf   = &cnt_q;
        end
        MODE_UPDN: begin
          if (period_i == '0) begin
            cnt_d = '0;
            dn_d  = 1'b0;
          end else if (!dn_q) begin
            if (cnt_q >= period_i) begin
              cnt_d = cnt_q - 1'b1;
              dn_d  = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (cnt_q <= CNT_W'(1)) begin
            cnt_d = '0;
            dn_d  = 1'b0;
            ovf   = (cnt_q == CNT_W'(1));
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf && !clr_i;

  AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && !clr_i) |=> $stable(cnt_q)); // R1
  AST_UP_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_UP && cnt_q == period_i && !clr_i) |=> (cnt_q == '0)); // R2
  AST_CONT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_CONT && (&cnt_q) && !clr_i) |=> (cnt_q == '0)); // R3
  AST_UD_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && mode_i == MODE_UPDN && !dn_q && cnt_q == period_i && period_i != '0 && !clr_i)
      |=> (cnt_q == $past(cnt_q) - 1'b1)); // R4
  AST_CLR_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dn_q)); // R7
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_SRC   = 4,
  parameter int DIV_SEL_W = 2,
  localparam int SRC_SEL_W = $clog2(NUM_SRC)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_SRC-1:0]   src_tick_i,
  input  logic [SRC_SEL_W-1:0] src_sel_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [1:0]           mode_i,
  input  logic [CNT_W-1:0]     period_i,
  input  logic                 clr_i,
  input  logic                 flag_clr_i,
  input  logic                 irq_en_i,
  output logic [CNT_W-1:0]     count_o,
  output logic                 equ0_o,
  output logic                 ovf_flag_o,
  output logic                 irq_o
);
  tmr_mode_e mode;
  logic      run, tick, ovf_evt, flag_q;

  assign mode = tmr_mode_e'(mode_i);
  assign run  = (mode != MODE_STOP);

  tmr_prescaler #(.NUM_SRC(NUM_SRC), .DIV_SEL_W(DIV_SEL_W)) u_pre (
    .clk_i, .rst_ni, .src_tick_i, .src_sel_i, .div_sel_i,
    .run_i(run), .clr_i, .tick_o(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .mode_i(mode), .period_i, .tick_i(tick), .clr_i,
    .count_o, .ovf_o(ovf_evt)
  );

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (ovf_evt)    flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign ovf_flag_o = flag_q;
  assign irq_o      = flag_q && irq_en_i;
  assign equ0_o     = run && (count_o == period_i);

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> flag_q); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !flag_clr_i) |=> flag_q); // R8
  AST_STOP_NO_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run) |-> !ovf_evt); // R1
endmodule

// File: tb/tb_mm_timer.sv
module tb_mm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  src_tick = '0;
  logic [1:0]  src_sel = '0, div_sel = '0, mode = '0;
  logic [15:0] period = '0;
  logic        clr = 1'b0, flag_clr = 1'b0, irq_en = 1'b0;
  logic [15:0] count;
  logic        equ0, flag, irq;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mm_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .src_tick_i(src_tick), .src_sel_i(src_sel),
    .div_sel_i(div_sel), .mode_i(mode), .period_i(period), .clr_i(clr),
    .flag_clr_i(flag_clr), .irq_en_i(irq_en), .count_o(count), .equ0_o(equ0),
    .ovf_flag_o(flag), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  div;
    logic [1:0]  src;
    logic [15:0] period;
    logic [7:0]  nt;
    logic [15:0] exp_cnt;
    logic        exp_flag;
    logic        exp_equ;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{2'b01, 2'b00, 2'd0, 16'd5, 8'd3,  16'd3, 1'b0, 1'b0, 4'd2},  // R2
    '{2'b01, 2'b00, 2'd0, 16'd5, 8'd6,  16'd0, 1'b1, 1'b0, 4'd2},  // R2 wrap
    '{2'b01, 2'b01, 2'd1, 16'd5, 8'd7,  16'd3, 1'b0, 1'b0, 4'd5},  // R5 /2
    '{2'b01, 2'b10, 2'd2, 16'd9, 8'd9,  16'd2, 1'b0, 1'b0, 4'd5},  // R5 /4
    '{2'b01, 2'b11, 2'd3, 16'd9, 8'd17, 16'd2, 1'b0, 1'b0, 4'd5},  // R5 /8
    '{2'b11, 2'b00, 2'd1, 16'd4, 8'd6,  16'd2, 1'b0, 1'b0, 4'd4},  // R4 descending
    '{2'b11, 2'b00, 2'd1, 16'd4, 8'd8,  16'd0, 1'b1, 1'b0, 4'd4},  // R4 bottom
    '{2'b11, 2'b00, 2'd1, 16'd4, 8'd10, 16'd2, 1'b1, 1'b0, 4'd4},  // R4 rising again
    '{2'b10, 2'b00, 2'd0, 16'd5, 8'd10, 16'd10, 1'b0, 1'b0, 4'd3}, // R3 passes period
    '{2'b00, 2'b00, 2'd0, 16'd5, 8'd5,  16'd0, 1'b0, 1'b0, 4'd1},  // R1
    '{2'b01, 2'b00, 2'd2, 16'd3, 8'd3,  16'd3, 1'b0, 1'b1, 4'd9}   // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr = 1'b1; flag_clr = 1'b1;
    step(1);
    clr = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    src_tick[src_sel] = 1'b1;
    step(n);
    src_tick = '0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(2);
    // reset state
    chk("R1 reset count", 32'(count), 0);
    chk("R8 reset flag", 32'(flag), 0);
    chk("R8 reset irq", 32'(irq), 0);
    chk("R9 reset equ0", 32'(equ0), 0);
    rst_n = 1'b1;
    step(1);

    foreach (VEC[i]) begin
      mode = VEC[i].mode; div_sel = VEC[i].div; src_sel = VEC[i].src;
      period = VEC[i].period;
      pulse_clr();
      ticks(int'(VEC[i].nt));
      step(1);
      chk($sformatf("R%0d vec%0d count", VEC[i].req, i), 32'(count), 32'(VEC[i].exp_cnt));
      chk($sformatf("R%0d vec%0d flag", VEC[i].req, i), 32'(flag), 32'(VEC[i].exp_flag));
      chk($sformatf("R%0d vec%0d equ0", VEC[i].req, i), 32'(equ0), 32'(VEC[i].exp_equ));
    end

    // R6: unselected sources ignored
    mode = 2'b01; div_sel = 2'b00; src_sel = 2'd0; period = 16'd100;
    pulse_clr();
    src_tick = 4'b1110; step(5); src_tick = '0; step(1);
    chk("R6 other sources", 32'(count), 0);

    // R7: clear beats tick, divider restarted
    ticks(2);
    src_tick[0] = 1'b1; clr = 1'b1; step(1); clr = 1'b0; src_tick = '0; step(1);
    chk("R7 clear wins", 32'(count), 0);
    div_sel = 2'b10;
    ticks(3); pulse_clr(); ticks(3); step(1);
    chk("R7 divider restart", 32'(count), 0);
    ticks(1); step(1);
    chk("R7 after 4 pulses", 32'(count), 1);

    // R7: direction reset by clear
    mode = 2'b11; div_sel = 2'b00; period = 16'd4;
    pulse_clr(); ticks(5); step(1);
    chk("R4 top turn", 32'(count), 3);
    pulse_clr(); ticks(1); step(1);
    chk("R7 direction up", 32'(count), 1);

    // R9: equ0 at top, gated in stop
    ticks(3); step(1);
    chk("R9 equ0 at period", 32'(equ0), 1);
    mode = 2'b00; step(1);
    chk("R9 equ0 stop", 32'(equ0), 0);
    ticks(4); step(1);
    chk("R1 stop holds", 32'(count), 4);

    // R8: irq gating, flag hold, set beats clear
    mode = 2'b01; period = 16'd2;
    pulse_clr(); irq_en = 1'b0; ticks(3); step(1);
    chk("R8 flag set", 32'(flag), 1);
    chk("R8 irq gated", 32'(irq), 0);
    irq_en = 1'b1; step(1);
    chk("R8 irq enabled", 32'(irq), 1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0; step(1);
    chk("R8 flag cleared", 32'(flag), 0);
    ticks(2);
    src_tick[0] = 1'b1; flag_clr = 1'b1; step(1); src_tick = '0; flag_clr = 1'b0; step(1);
    chk("R8 set wins", 32'(flag), 1);
    irq_en = 1'b0;

    // R3: full-range wrap in continuous mode
    mode = 2'b10; period = 16'd5;
    pulse_clr(); ticks(65535); step(1);
    chk("R3 reach max", 32'(count), 32'hFFFF);
    chk("R3 no flag before wrap", 32'(flag), 0);
    ticks(1); step(1);
    chk("R3 wrap count", 32'(count), 0);
    chk("R3 wrap flag", 32'(flag), 1);

    // R10: period lowered below count in up mode
    mode = 2'b01; period = 16'd10;
    pulse_clr(); ticks(8);
    period = 16'd3;
    ticks(65527); step(1);
    chk("R10 reach max", 32'(count), 32'hFFFF);
    ticks(1); step(1);
    chk("R10 wrap count", 32'(count), 0);
    chk("R10 no flag at wrap", 32'(flag), 0);
    ticks(3); step(1);
    chk("R10 resumes", 32'(count), 3);
    ticks(1); step(1);
    chk("R10 period wrap", 32'(count), 0);
    chk("R10 period flag", 32'(flag), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule